// File: doc/BRIEF.md
# Banked Nonvolatile Register Store

This block models sixteen 8-bit nonvolatile data registers, organised as four banks of four, behind a command interface that sits next to a digitally controlled potentiometer. Flip-flops stand in for the nonvolatile cells. Every store is slowed down on purpose: a request is captured when it is accepted. The register then changes only at the end of a busy window whose length, WR_CYCLES, is counted in system clocks. A one-bit write-in-progress flag shows whether that window is open.

Two producers can store data, and each uses a valid/ready handshake:
- **Direct-write channel.** Takes a bank, a register index and a data byte.
- **Wiper-save channel.** Copies the current wiper value into one of the bank-0 registers.

Back-pressure follows three rules:
- Both ready signals are low while the busy window is open. A request offered then is not taken. Nothing queues it; the producer keeps holding it or withdraws it.
- If both channels offer in the same idle cycle, the direct write wins and the save channel sees ready low.
- A write-protect input (active low) lets the handshake complete but throws the request away.

On the read side:
- A combinational read port returns any register.
- A load port returns a bank-0 register to the wiper one cycle later.
- After reset, the block sends bank 0 register 0 to the wiper once, as the power-up default.

Top module: `nvs_bank_store`

## Requirements
- R1: Register (bank b, index r) is cell 4*b+r. `rd_data` shows the stored value of (`rd_bank`, `rd_reg`) in the same cycle.
- R2: While `rst_n` is low, every register holds INIT_VAL, `wip` is 0, both ready outputs are 1 and `wiper_load_valid` is 0.
- R3: In the cycle after the first rising edge with `rst_n` high, `wiper_load_valid` is 1 and `wiper_load_data` equals bank 0 register 0.
- R4: A direct write is accepted when `wr_valid` and `wr_ready` are both 1 at an edge with `wp_n` = 1. After that edge, `wip` is 1 for exactly WR_CYCLES cycles. The register takes the data at the edge where `wip` falls.
- R5: A save accepted on the wiper-save channel writes bank 0 register `sv_reg` with `sv_data`, with the same timing as R4. `sv_ready` is 0 whenever `wr_valid` is 1, so the direct write wins.
- R6: While `wip` is 1, `wr_ready` and `sv_ready` are 0. A request offered in that time changes no register.
- R7: With `wp_n` = 0, an offered request completes its handshake but starts no busy window (`wip` stays 0) and leaves every register unchanged.
- R8: During the busy window, reads return the register's old value.
- R9: `ld_valid` with index `ld_reg` gives `wiper_load_valid` = 1 in the next cycle, with `wiper_load_data` equal to bank 0 register `ld_reg`. Otherwise `wiper_load_valid` is 0.
- R10: Banks 1 to 3 are independent storage. A write to bank 1 register 0 leaves bank 0 register 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write protect, active low |
| wr_valid | input | 1 | Direct write request valid |
| wr_ready | output | 1 | Direct write request ready |
| wr_bank | input | 2 | Direct write bank |
| wr_reg | input | 2 | Direct write register index |
| wr_data | input | DATA_W | Direct write data |
| sv_valid | input | 1 | Wiper-save request valid |
| sv_ready | output | 1 | Wiper-save request ready |
| sv_reg | input | 2 | Bank-0 destination register |
| sv_data | input | DATA_W | Wiper value to save |
| rd_bank | input | 2 | Read bank |
| rd_reg | input | 2 | Read register index |
| rd_data | output | DATA_W | Read data |
| ld_valid | input | 1 | Load a bank-0 register to the wiper |
| ld_reg | input | 2 | Bank-0 source register |
| wiper_load_valid | output | 1 | Wiper load strobe |
| wiper_load_data | output | DATA_W | Value for the wiper |
| wip | output | 1 | Write in progress |

## Verification
The bench probes several corner cases:
- **Early update.** It reads the target register in the middle of the busy window. A design that updates at acceptance would return the new value too soon.
- **Requests during the busy window.** It holds a second write while the window is open. A design that lets it in would corrupt the pending store.
- **Write protect.** It offers a request with protect asserted. A design that ignores protect would raise `wip` and change the register.
- **Simultaneous offers.** It offers both channels at once. Wrong arbitration would store the saved wiper value instead of the direct write.
- **Power-up recall.** It checks the recall strobe after reset. A missing strobe leaves the wiper unset.
- **Bank decode.** It checks that a bank-1 write leaves bank 0 untouched. Faulty decode would overwrite the wiper default.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int BANK_W  = 2;
  localparam int IDX_W   = 2;
  localparam int CELL_AW = BANK_W + IDX_W;
  localparam int N_CELLS = 1 << CELL_AW;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [IDX_W-1:0]  idx;
  } nvs_addr_t;

  function automatic logic [CELL_AW-1:0] cell_of(nvs_addr_t a);
    return {a.bank, a.idx};
  endfunction
endpackage

// File: rtl/nvs_cell_array.sv
module nvs_cell_array
  import nvs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  nvs_addr_t         waddr,
  input  logic [DATA_W-1:0] wdata,
  input  nvs_addr_t         raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  ld_idx,
  output logic [DATA_W-1:0] ld_data
);
  logic [DATA_W-1:0] cells [N_CELLS];
  logic [CELL_AW-1:0] widx;
  assign widx = cell_of(waddr);

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= INIT_VAL;
      else if (we && widx == CELL_AW'(g))
        cells[g] <= wdata;
    end
  end

  assign rdata   = cells[cell_of(raddr)];
  // bank 0 occupies the lowest cells, so the index alone selects it
  assign ld_data = cells[{{BANK_W{1'b0}}, ld_idx}];
endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WR_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/nvs_req_select.sv
module nvs_req_select
  import nvs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  logic              wp_n,
  input  logic              wr_valid,
  input  nvs_addr_t         wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sv_valid,
  input  logic [IDX_W-1:0]  sv_reg,
  input  logic [DATA_W-1:0] sv_data,
  output logic              wr_ready,
  output logic              sv_ready,
  output logic              start,
  output nvs_addr_t         sel_addr,
  output logic [DATA_W-1:0] sel_data
);
  logic wr_take, sv_take;

  assign wr_ready = !busy;
  assign sv_ready = !busy && !wr_valid;
  assign wr_take  = wr_valid && wr_ready;
  assign sv_take  = sv_valid && sv_ready;
  assign start    = (wr_take || sv_take) && wp_n;

  always_comb begin
    if (wr_take) begin
      sel_addr = wr_addr;
      sel_data = wr_data;
    end else begin
      sel_addr.bank = '0;
      sel_addr.idx  = sv_reg;
      sel_data      = sv_data;
    end
  end
endmodule

// File: rtl/nvs_bank_store.sv
module nvs_bank_store
  import nvs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WR_CYCLES = 16,
  parameter logic [DATA_W-1:0] INIT_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_bank,
  input  logic [1:0]        wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sv_valid,
  output logic              sv_ready,
  input  logic [1:0]        sv_reg,
  input  logic [DATA_W-1:0] sv_data,
  input  logic [1:0]        rd_bank,
  input  logic [1:0]        rd_reg,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ld_valid,
  input  logic [1:0]        ld_reg,
  output logic              wiper_load_valid,
  output logic [DATA_W-1:0] wiper_load_data,
  output logic              wip
);
  nvs_addr_t         wr_addr, rd_addr, sel_addr, pend_addr;
  logic [DATA_W-1:0] sel_data, pend_data, ld_data;
  logic              start, done, recall_q;
  logic [IDX_W-1:0]  ld_idx;

  assign wr_addr = '{bank: wr_bank, idx: wr_reg};
  assign rd_addr = '{bank: rd_bank, idx: rd_reg};

  nvs_req_select #(.DATA_W(DATA_W)) u_sel (
    .busy(wip), .wp_n(wp_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .sv_valid(sv_valid), .sv_reg(sv_reg), .sv_data(sv_data),
    .wr_ready(wr_ready), .sv_ready(sv_ready), .start(start),
    .sel_addr(sel_addr), .sel_data(sel_data)
  );

  nvs_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done)
  );

  // request captured at acceptance, committed when the window closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_data <= '0;
    end else if (start) begin
      pend_addr <= sel_addr;
      pend_data <= sel_data;
    end
  end

  assign ld_idx = recall_q ? '0 : ld_reg;

  nvs_cell_array #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_cells (
    .clk(clk), .rst_n(rst_n), .we(done), .waddr(pend_addr),
    .wdata(pend_data), .raddr(rd_addr), .rdata(rd_data),
    .ld_idx(ld_idx), .ld_data(ld_data)
  );

  // power-up recall of bank 0 register 0, then on-demand loads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q         <= 1'b1;
      wiper_load_valid <= 1'b0;
      wiper_load_data  <= '0;
    end else begin
      recall_q         <= 1'b0;
      wiper_load_valid <= recall_q || ld_valid;
      if (recall_q || ld_valid) wiper_load_data <= ld_data;
    end
  end
endmodule

// File: rtl/nvs_store_chk.sv
module nvs_store_chk #(
  parameter int DATA_W = 8,
  parameter int WR_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              wip,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              sv_valid,
  input logic              sv_ready,
  input logic [1:0]        rd_bank,
  input logic [1:0]        rd_reg,
  input logic [DATA_W-1:0] rd_data
);
  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= 0;
    else if (wip) run_len <= run_len + 1;
    else          run_len <= 0;
  end

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (!wr_ready && !sv_ready));
  // R5
  wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sv_ready);
  // R4
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wp_n) |=> wip);
  // R5
  sv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_valid && sv_ready && wp_n) |=> wip);
  // R7
  protect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && !wp_n) |=> !wip);
  // R8
  hold_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip) && $stable(rd_bank) && $stable(rd_reg)) |-> $stable(rd_data));
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= WR_CYCLES);
endmodule

bind nvs_bank_store nvs_store_chk #(.DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wip(wip),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .sv_valid(sv_valid), .sv_ready(sv_ready),
  .rd_bank(rd_bank), .rd_reg(rd_reg), .rd_data(rd_data)
);

// File: tb/tb_nvs_bank_store.sv
module tb_nvs_bank_store;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 16;
  localparam int INIT = 8'h80;

  logic clk = 0, rst_n = 0, wp_n = 1;
  logic wr_valid = 0, sv_valid = 0, ld_valid = 0;
  logic [1:0] wr_bank = 0, wr_reg = 0, sv_reg = 0, rd_bank = 0, rd_reg = 0, ld_reg = 0;
  logic [7:0] wr_data = 0, sv_data = 0;
  logic wr_ready, sv_ready, wiper_load_valid, wip;
  logic [7:0] rd_data, wiper_load_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvs_bank_store #(.DATA_W(8), .WR_CYCLES(WRC), .INIT_VAL(8'(INIT))) dut (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mem [16];
  int pend_cnt = 0, pend_idx = 0, pend_dat = 0;
  bit recall = 1, m_wlv = 0;
  int m_wld = 0;
  initial foreach (mem[i]) mem[i] = INIT;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = INIT;
      pend_cnt = 0; recall = 1; m_wlv = 0; m_wld = 0;
    end else begin
      if (recall) begin m_wlv = 1; m_wld = mem[0]; end
      else if (ld_valid) begin m_wlv = 1; m_wld = mem[ld_reg]; end
      else m_wlv = 0;
      recall = 0;
      if (pend_cnt > 0) begin
        if (pend_cnt == 1) mem[pend_idx] = pend_dat;
        pend_cnt--;
      end else if (wp_n && wr_valid) begin
        pend_cnt = WRC; pend_idx = wr_bank * 4 + wr_reg; pend_dat = wr_data;
      end else if (wp_n && sv_valid) begin
        pend_cnt = WRC; pend_idx = sv_reg; pend_dat = sv_data;
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    chk("R4 wip", wip, pend_cnt > 0);
    chk("R6 wr_ready", wr_ready, pend_cnt == 0);
    chk("R5 sv_ready", sv_ready, pend_cnt == 0 && !wr_valid);
    chk("R1 rd_data", rd_data, mem[rd_bank * 4 + rd_reg]);
    chk("R3 R9 wiper_load_valid", wiper_load_valid, m_wlv);
    if (m_wlv) chk("R3 R9 wiper_load_data", wiper_load_data, m_wld);
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wait_n(input int n); repeat (n) step(); endtask

  task automatic rd_chk(input int b, input int r, input int exp, input string tag);
    rd_bank = 2'(b); rd_reg = 2'(r); #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input int b, input int r, input int d);
    step(); wr_valid = 1; wr_bank = 2'(b); wr_reg = 2'(r); wr_data = 8'(d);
    step(); wr_valid = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(3);
    // R2 reset state
    chk("R2 wip", wip, 0);
    chk("R2 wr_ready", wr_ready, 1);
    rd_chk(2, 3, INIT, "R2 reset value");
    rst_n = 1;
    step();
    chk("R3 recall strobe", wiper_load_valid, 1);
    chk("R3 recall data", wiper_load_data, INIT);

    // R4 R8 R6: write, read in window, blocked second write
    wr(0, 1, 8'h5A);
    rd_chk(0, 1, INIT, "R8 old value while busy");
    wait_n(2);
    wr_valid = 1; wr_bank = 2; wr_reg = 1; wr_data = 8'hEE;
    wait_n(2); wr_valid = 0;
    wait_n(WRC);
    rd_chk(0, 1, 8'h5A, "R4 committed value");
    rd_chk(2, 1, INIT, "R6 blocked write");

    // R10 bank independence
    wr(1, 0, 8'h33);
    wait_n(WRC + 1);
    rd_chk(1, 0, 8'h33, "R10 bank1 written");
    rd_chk(0, 0, INIT, "R10 bank0 untouched");

    // R7 write protect
    wp_n = 0;
    wr(2, 2, 8'h77);
    chk("R7 no busy", wip, 0);
    rd_chk(2, 2, INIT, "R7 register unchanged");
    wp_n = 1;

    // R5 priority then save alone
    step();
    wr_valid = 1; wr_bank = 3; wr_reg = 1; wr_data = 8'h11;
    sv_valid = 1; sv_reg = 3; sv_data = 8'hC4;
    step(); wr_valid = 0; sv_valid = 0;
    wait_n(WRC + 1);
    rd_chk(3, 1, 8'h11, "R5 direct write wins");
    rd_chk(0, 3, INIT, "R5 save dropped");
    step(); sv_valid = 1;
    step(); sv_valid = 0;
    wait_n(WRC + 1);
    rd_chk(0, 3, 8'hC4, "R5 save committed");

    // R9 load to wiper
    step(); ld_valid = 1; ld_reg = 1;
    step(); ld_valid = 0;
    chk("R9 load valid", wiper_load_valid, 1);
    chk("R9 load data", wiper_load_data, 8'h5A);
    step();
    chk("R9 strobe ends", wiper_load_valid, 0);

    // R1 full readback
    for (int i = 0; i < 16; i++) rd_chk(i / 4, i % 4, mem[i], "R1 readback");
    wait_n(2);
    finish_run();
  end
endmodule